// File: doc/BRIEF.md
# Keyed Configuration Item Reader

This block is a small memory-mapped register window through which a guest reads configuration items from a store. Each item is a byte string of its own length, addressed by a 16-bit key. Software writes the key into a write-only selector register, which also rewinds the read cursor to the start of the item. Software then pulls bytes from a data register one access at a time. Each access may be 1, 2, 4 or 8 bytes wide, and the cursor moves forward by that many bytes.

Item contents come from arithmetic inside the block, so no memory has to be loaded. There is a signature item, a feature word, a set of generic items and a set of architecture-specific items. Bytes beyond the end of an item read as zero. The cursor stops at its ceiling and never wraps, so an item that has been read past its end stays exhausted.

Top module: `cfgitem_port`

## Requirements
- R1: After reset `bus_rvalid` and `bus_rdata` are zero, the current key is 0 and the cursor is 0. A first 4-byte data read therefore returns the signature.
- R2: A 16-bit write (size code 1) at window offset 8 loads the key and clears the cursor. The key is big-endian: byte lane 0 holds key bits 15:8 and lane 1 holds key bits 7:0. A write of any other size at offset 8 is ignored.
- R3: Key bit 15 selects the architecture-specific group (set) or the generic group (clear). Bits 13:0 give the item index. Bit 14 has no effect on which item is read.
- R4: A read at offset 0 with size code s returns N = 2^s item bytes. The byte at cursor+k is placed on lane k, which is bits 8k+7:8k. Lanes k >= N read as zero. `bus_rvalid` is high exactly in the cycle after each read request cycle, and `bus_rdata` is valid in that cycle.
- R5: Each data read moves the cursor forward by N bytes.
- R6: A byte whose position is at or past the item length reads as 0x00. This includes the bytes of a read that straddles the end of the item.
- R7: The cursor saturates at 2^OFF_W-1 and never wraps back into item data.
- R8: Generic index 0 is the signature item. It is 4 bytes long and holds 0x4B 0x43 0x46 0x47 ("KCFG").
- R9: Generic index 1 is a 4-byte little-endian feature word. Its byte 0 is 0x01 | (FEAT_DMA<<1) and its other bytes are 0.
- R10: For generic index i with 2 <= i < NUM_GEN, the item length is 5i and byte j is (16i+j) mod 256. For architecture index a < NUM_ARCH, the length is 3+2a and byte j is (0x80+32a+j) mod 256. Any other index has length 0.
- R11: Writes to the data register change neither the key nor the cursor. A read of offset 8 (the selector), 16 or 24 returns zero and does not move the cursor. Writes to offset 16 or 24 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset inside the window |
| bus_size | input | 2 | Access size code, N = 2^size bytes |
| bus_wdata | input | 64 | Write data, lane k = byte at offset+k |
| bus_rdata | output | 64 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |

## Verification
The hardest condition to reach from the ports is the cursor ceiling. An item is at most a few dozen bytes long, but the cursor only reaches its limit after about 32 full-width reads. A wrapping cursor would show item bytes again at that point. To get there, the bench selects a short item and issues 40 consecutive 8-byte reads, and it checks that every read past the end returns zero. A second hard case is a read that straddles the end of an item. The bench reaches every straddle offset by sweeping every key, including missing keys and bit-14 aliases, under every access size, all the way from offset 0 to past the end.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int KEY_W     = 16;
  localparam int IDX_W     = 14;
  localparam int BUS_BYTES = 8;

  typedef enum logic [1:0] {
    ACC_B = 2'd0,
    ACC_H = 2'd1,
    ACC_W = 2'd2,
    ACC_D = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RG_DATA = 2'd0,
    RG_KEY  = 2'd1,
    RG_DMA  = 2'd2,
    RG_NONE = 2'd3
  } win_reg_e;

  typedef struct packed {
    logic             present;
    logic             arch;
    logic [IDX_W-1:0] idx;
  } key_info_t;

  function automatic logic [7:0] sig_byte(input logic [1:0] pos);
    case (pos)
      2'd0:    sig_byte = 8'h4B;
      2'd1:    sig_byte = 8'h43;
      2'd2:    sig_byte = 8'h46;
      default: sig_byte = 8'h47;
    endcase
  endfunction

endpackage

// File: rtl/cfg_key_decode.sv
module cfg_key_decode
  import cfgport_pkg::*;
#(
  parameter int NUM_GEN  = 6,
  parameter int NUM_ARCH = 3
) (
  input  logic [KEY_W-1:0] key,
  output key_info_t        info
);

  logic             arch;
  logic [IDX_W-1:0] idx;

  assign arch = key[15];
  assign idx  = key[IDX_W-1:0];

  always_comb begin
    info.arch = arch;
    info.idx  = idx;
    if (arch) info.present = (int'(idx) < NUM_ARCH);
    else      info.present = (int'(idx) < NUM_GEN);
  end

endmodule

// File: rtl/cfg_item_store.sv
module cfg_item_store
  import cfgport_pkg::*;
#(
  parameter int OFF_W    = 8,
  parameter bit FEAT_DMA = 1'b0
) (
  input  key_info_t              info,
  input  logic [OFF_W-1:0]       off,
  output logic [OFF_W-1:0]       len,
  output logic [8*BUS_BYTES-1:0] lanes
);

  always_comb begin
    if (!info.present)
      len = '0;
    else if (info.arch)
      len = OFF_W'(3 + 2 * int'(info.idx));
    else if (int'(info.idx) < 2)
      len = OFF_W'(4);
    else
      len = OFF_W'(5 * int'(info.idx));
  end

  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
    logic [OFF_W:0] pos;
    logic [7:0]     raw;

    assign pos = {1'b0, off} + (OFF_W+1)'(k);

    always_comb begin
      if (!info.present)
        raw = 8'h00;
      else if (info.arch)
        raw = 8'(128 + 32 * int'(info.idx) + int'(pos));
      else if (int'(info.idx) == 0)
        raw = sig_byte(pos[1:0]);
      else if (int'(info.idx) == 1)
        raw = (pos == '0) ? {6'b0, FEAT_DMA, 1'b1} : 8'h00;
      else
        raw = 8'(16 * int'(info.idx) + int'(pos));
    end

    assign lanes[8*k +: 8] = (pos < {1'b0, len}) ? raw : 8'h00;
  end

endmodule

// File: rtl/cfg_cursor.sv
module cfg_cursor
  import cfgport_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_in,
  input  logic             step_en,
  input  logic [3:0]       step_n,
  output logic [KEY_W-1:0] key_q,
  output logic [OFF_W-1:0] off_q
);

  logic [KEY_W-1:0] key_d;
  logic [OFF_W-1:0] off_d;
  logic [OFF_W:0]   sum;
  logic             upd_en;

  assign sum    = {1'b0, off_q} + (OFF_W+1)'(step_n);
  assign upd_en = key_we | step_en;

  always_comb begin
    key_d = key_q;
    off_d = off_q;
    if (key_we) begin
      key_d = key_in;
      off_d = '0;
    end else if (step_en) begin
      off_d = sum[OFF_W] ? '1 : sum[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      off_q <= '0;
    end else if (upd_en) begin
      key_q <= key_d;
      off_q <= off_d;
    end
  end

endmodule

// File: rtl/cfgitem_port.sv
module cfgitem_port
  import cfgport_pkg::*;
#(
  parameter int NUM_GEN  = 6,
  parameter int NUM_ARCH = 3,
  parameter int OFF_W    = 8,
  parameter bit FEAT_DMA = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [63:0] bus_wdata,
  output logic [63:0] bus_rdata,
  output logic        bus_rvalid
);

  localparam int DW = 8 * BUS_BYTES;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  win_reg_e         region;
  logic             lane_zero;
  logic [3:0]       nbytes;
  logic             rd_req;
  logic             data_rd;
  logic             key_wr;
  logic [KEY_W-1:0] key_in;
  logic [KEY_W-1:0] cur_key;
  logic [OFF_W-1:0] cur_off;
  logic [OFF_W-1:0] item_len;
  key_info_t        info;
  logic [DW-1:0]    lanes;
  logic [DW-1:0]    size_mask;
  logic [DW-1:0]    rdata_d;
  logic [DW-1:0]    rdata_q;
  logic             rvalid_d;
  logic             rvalid_q;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // window decode
  assign region    = win_reg_e'(bus_addr[4:3]);
  assign lane_zero = (bus_addr[2:0] == 3'd0);
  assign nbytes    = 4'd1 << bus_size;
  assign rd_req    = bus_req & ~bus_we;
  assign data_rd   = rd_req & lane_zero & (region == RG_DATA);
  assign key_wr    = bus_req & bus_we & lane_zero & (region == RG_KEY) &
                     (acc_size_e'(bus_size) == ACC_H);
  assign key_in    = {bus_wdata[7:0], bus_wdata[15:8]};

  cfg_cursor #(.OFF_W(OFF_W)) u_cursor (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .key_we  (key_wr),
    .key_in  (key_in),
    .step_en (data_rd),
    .step_n  (nbytes),
    .key_q   (cur_key),
    .off_q   (cur_off)
  );

  cfg_key_decode #(.NUM_GEN(NUM_GEN), .NUM_ARCH(NUM_ARCH)) u_decode (
    .key  (cur_key),
    .info (info)
  );

  cfg_item_store #(.OFF_W(OFF_W), .FEAT_DMA(FEAT_DMA)) u_store (
    .info  (info),
    .off   (cur_off),
    .len   (item_len),
    .lanes (lanes)
  );

  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_mask
    assign size_mask[8*k +: 8] = (k < int'(nbytes)) ? 8'hFF : 8'h00;
  end

  // response stage
  assign rdata_d  = data_rd ? (lanes & size_mask) : '0;
  assign rvalid_d = rd_req;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      if (rd_req) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/cfgitem_port_chk.sv
module cfgitem_port_chk #(
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_we,
  input logic [4:0]       bus_addr,
  input logic [1:0]       bus_size,
  input logic [63:0]      bus_rdata,
  input logic             bus_rvalid,
  input logic [15:0]      cur_key,
  input logic [OFF_W-1:0] cur_off
);

  logic           rd_any;
  logic           rd_data;
  logic           wr_data;
  logic           wr_key;
  logic [3:0]     nb;
  logic [OFF_W:0] step_sum;

  assign rd_any   = bus_req && !bus_we;
  assign rd_data  = rd_any && (bus_addr == 5'd0);
  assign wr_data  = bus_req && bus_we && (bus_addr == 5'd0);
  assign wr_key   = bus_req && bus_we && (bus_addr == 5'd8) && (bus_size == 2'd1);
  assign nb       = 4'd1 << bus_size;
  assign step_sum = {1'b0, cur_off} + (OFF_W+1)'(nb);

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> bus_rvalid); // R4
  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> !bus_rvalid); // R4
  AST_BYTE_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && bus_size == 2'd0) |=> (bus_rdata[63:8] == 56'd0)); // R4
  AST_KEY_CLEARS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_key |=> (cur_off == '0)); // R2
  AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !step_sum[OFF_W]) |=> ({1'b0, cur_off} == $past(step_sum))); // R5
  AST_OFF_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data |=> (cur_off >= $past(cur_off))); // R7
  AST_DATA_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> ($stable(cur_off) && $stable(cur_key))); // R11

endmodule

bind cfgitem_port cfgitem_port_chk #(.OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_size   (bus_size),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .cur_key    (cur_key),
  .cur_off    (cur_off)
);

// File: tb/sim_cfgitem_port.sv
`timescale 1ns/1ps
module sim_cfgitem_port;

  localparam int NG    = 6;
  localparam int NA    = 3;
  localparam int OW    = 8;
  localparam int OMAX  = (1 << OW) - 1;

  logic        clk;
  logic        rst_n;
  logic        bus_req;
  logic        bus_we;
  logic [4:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic        bus_rvalid;

  int total;
  int bad;
  int cycles;

  cfgitem_port #(.NUM_GEN(NG), .NUM_ARCH(NA), .OFF_W(OW), .FEAT_DMA(1'b0)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp<=150000", cycles);
        finish_run();
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // reference model from the requirements
  function automatic int m_len(input logic [15:0] key);
    int idx;
    idx = int'(key[13:0]);
    if (key[15]) return (idx < NA) ? 3 + 2 * idx : 0;
    if (idx >= NG) return 0;
    if (idx < 2) return 4;
    return 5 * idx;
  endfunction

  function automatic logic [7:0] m_byte(input logic [15:0] key, input int pos);
    int idx;
    logic [31:0] sig;
    idx = int'(key[13:0]);
    sig = 32'h4746434B;
    if (pos >= m_len(key)) return 8'h00;
    if (key[15]) return 8'(128 + 32 * idx + pos);
    if (idx == 0) return sig[8*pos +: 8];
    if (idx == 1) return (pos == 0) ? 8'h01 : 8'h00;
    return 8'(16 * idx + pos);
  endfunction

  function automatic logic [63:0] m_word(input logic [15:0] key, input int off, input int n);
    logic [63:0] w;
    w = '0;
    for (int k = 0; k < n; k++) w[8*k +: 8] = m_byte(key, off + k);
    return w;
  endfunction

  task automatic bus_rd(input logic [4:0] a, input logic [1:0] s,
                        output logic [63:0] d, output logic v);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = s; bus_wdata = '0;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
    v = bus_rvalid;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [1:0] s, input logic [63:0] w);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = s; bus_wdata = w;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic select(input logic [15:0] key);
    bus_wr(5'd8, 2'd1, {48'd0, key[7:0], key[15:8]});
  endtask

  // sweep one key at one size from offset 0 to past the end
  task automatic sweep(input logic [15:0] key, input logic [1:0] s);
    int off;
    int n;
    logic [63:0] d;
    logic v;
    n = 1 << s;
    off = 0;
    select(key);
    while (off < m_len(key) + 8) begin
      bus_rd(5'd0, s, d, v);
      if (!v) check("R4 rvalid", 64'(v), 64'd1);
      check($sformatf("R3 R4 R5 R6 R10 key=%h size=%0d off=%0d", key, s, off),
            d, m_word(key, off, n));
      off = (off + n > OMAX) ? OMAX : off + n;
    end
  endtask

  initial begin
    logic [63:0] d;
    logic v;
    logic [15:0] keys [20];
    int mo;

    total = 0;
    bad   = 0;
    rst_n = 1'b0;
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rvalid in reset", 64'(bus_rvalid), 64'd0);
    check("R1 rdata in reset", bus_rdata, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 / R8: first read with no selection gives the signature
    bus_rd(5'd0, 2'd2, d, v);
    check("R1 R8 signature", d, 64'h0000_0000_4746_434B);
    check("R4 rvalid", 64'(v), 64'd1);
    @(negedge clk);
    check("R4 rvalid drops", 64'(bus_rvalid), 64'd0);

    // R9: feature word
    select(16'h0001);
    bus_rd(5'd0, 2'd2, d, v);
    check("R9 feature", d, 64'h0000_0000_0000_0001);

    // full sweep of keys and sizes
    for (int i = 0; i <= NG; i++) keys[i] = 16'(i);
    keys[7]  = 16'h4000;
    keys[8]  = 16'h4002;
    keys[9]  = 16'h4005;
    for (int a = 0; a <= NA; a++) keys[10 + a] = 16'h8000 + 16'(a);
    keys[14] = 16'hC000;
    keys[15] = 16'hC002;
    keys[16] = 16'h3FFF;
    keys[17] = 16'hBFFF;
    keys[18] = 16'h0003;
    keys[19] = 16'h8001;
    for (int i = 0; i < 20; i++)
      for (int s = 0; s < 4; s++)
        sweep(keys[i], 2'(s));

    // R3: alias with bit 14 reads the same bytes
    select(16'h4004);
    bus_rd(5'd0, 2'd3, d, v);
    check("R3 bit14 alias", d, m_word(16'h0004, 0, 8));

    // R7: drive the cursor to its ceiling on a short item
    select(16'h0002);
    mo = 0;
    for (int r = 0; r < 40; r++) begin
      bus_rd(5'd0, 2'd3, d, v);
      check($sformatf("R7 R6 saturate read %0d", r), d, m_word(16'h0002, mo, 8));
      mo = (mo + 8 > OMAX) ? OMAX : mo + 8;
    end

    // R11: data writes, selector reads, spare slot accesses are inert
    select(16'h0003);
    bus_rd(5'd0, 2'd0, d, v);
    check("R11 setup", d, 64'h30);
    bus_wr(5'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_rd(5'd8, 2'd1, d, v);
    check("R11 selector reads zero", d, 64'd0);
    bus_rd(5'd16, 2'd3, d, v);
    check("R11 slot16 reads zero", d, 64'd0);
    bus_rd(5'd24, 2'd3, d, v);
    check("R11 slot24 reads zero", d, 64'd0);
    bus_wr(5'd16, 2'd3, 64'h1234);
    bus_rd(5'd0, 2'd0, d, v);
    check("R11 cursor kept", d, 64'h31);

    // R2: non-16-bit selector write ignored; byte order of the key
    bus_wr(5'd8, 2'd2, 64'h0000_0000_0000_0080);
    bus_rd(5'd0, 2'd0, d, v);
    check("R2 wrong size ignored", d, 64'h32);
    bus_wr(5'd8, 2'd1, 64'h0000_0000_0000_0280);
    bus_rd(5'd0, 2'd1, d, v);
    check("R2 big-endian key 0x8002", d, m_word(16'h8002, 0, 2));
    select(16'h0003);
    bus_rd(5'd0, 2'd1, d, v);
    check("R2 offset cleared", d, 64'h3130);

    finish_run();
  end

endmodule